// File: doc/BRIEF.md
# ADC Result Window Gate

This block sits between the sample output of an analog-to-digital converter core and the result register that software reads. Each time the core reports a finished conversion, the block compares the sample against a programmable lower bound and a programmable upper bound. A window-mode bit chooses which results count as accepted. In one setting, results inside the bounds are accepted, with both bounds included. In the other setting, results outside the bounds are accepted, and a result equal to a bound is not. An accepted sample is written to the result register and produces a single-cycle end-of-conversion interrupt. A rejected sample is discarded, and no interrupt is raised.

A small mode register holds three controls: the resolution select (full 12-bit or reduced 8-bit compare), the window-mode bit and an auto-wake enable. The mode register can only be written while the converter is idle. The auto-wake enable takes effect only when hardware triggering with a stabilisation wait is in use and sequential conversion is off. With any other trigger setting, a hardware trigger raises no wake request.

Top module: `adc_window_gate`

## Requirements
- R1: After reset, the mode register reads 0x00, the lower bound is 0x000, the upper bound is 0xFFF, the result is 0x000 and the interrupt is low. In this state every sample, from 0x000 to 0xFFF, is accepted.
- R2: With window-mode 0, a sample is accepted when lower ≤ sample ≤ upper, both bounds included. An accepted sample appears on `result` in the cycle after the `conv_done` strobe.
- R3: With window-mode 1, a sample is accepted when sample < lower or upper < sample. A sample equal to either bound is rejected.
- R4: `conv_irq` is high for exactly the one cycle after a `conv_done` strobe whose sample was accepted, and it is low in every other cycle.
- R5: After a rejected sample, `result` and `result_hi` keep their previous values.
- R6: With resolution bit 1 (8-bit), the compare uses only bits 11:4 of the sample and of each bound. With resolution bit 0, it uses all 12 bits.
- R7: `result_hi` always equals bits 11:4 of `result`.
- R8: Register address 0 is the mode register. Bit 0 is resolution, bit 2 is auto-wake enable and bit 3 is window-mode. Bits 1 and 4 to 7 read 0, so a write of 0xFF reads back as 0x0D. Address 1 is the lower bound and address 2 is the upper bound, each 12 bits wide.
- R9: A write to address 0 has no effect while `conv_enable` or `conv_start` is high. Writes to the bounds are never blocked.
- R10: `wake_req` is high only when auto-wake enable is 1, `hw_trig` is high, `trig_sel` is 2'b10 (hardware trigger with wait) and `seq_mode` is 0. The other `trig_sel` codes are 2'b00 (software), 2'b01 (hardware, no wait) and 2'b11 (reserved). With any of these codes, `wake_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe from the converter core: a sample is ready |
| conv_result | input | 12 | Sample from the converter core, valid with conv_done |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 lower bound, 2 upper bound |
| reg_wdata | input | 12 | Write data; the mode register takes bits 7:0 |
| conv_enable | input | 1 | Converter enabled; blocks mode writes |
| conv_start | input | 1 | Conversion running; blocks mode writes |
| hw_trig | input | 1 | Hardware trigger event |
| trig_sel | input | 2 | Trigger setting: 00 software, 01 hardware no-wait, 10 hardware wait, 11 reserved |
| seq_mode | input | 1 | Sequential conversion selected |
| result | output | 12 | Stored accepted sample |
| result_hi | output | 8 | Upper eight bits of result |
| conv_irq | output | 1 | End-of-conversion interrupt pulse |
| mode_rd | output | 8 | Mode register read value |
| wake_req | output | 1 | Auto-wake conversion request |

## Verification
The assertions assume that `conv_done` and `conv_result` change only between clock edges and that `conv_done` is never high while reset is asserted. The store and interrupt checks also assume that the bound registers are not rewritten in the same cycle as a strobe the checker is judging. The stimulus drives every input on the falling edge and draws samples and bounds from `$urandom` with a fixed seed. It clusters many samples within a few codes of each bound, so that the inclusive and strict edges of both window modes are exercised. Directed sequences add the 8-bit compare boundaries, mode writes made while the converter is busy, and every trigger setting for the wake request.

// File: rtl/adc_wg_pkg.sv
package adc_wg_pkg;
  localparam int MODE_W    = 8;
  localparam int MB_RES8   = 0;
  localparam int MB_WAKE   = 2;
  localparam int MB_WINOUT = 3;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;

  typedef enum logic [1:0] {
    TRIG_SW      = 2'b00,
    TRIG_HW_NOWT = 2'b01,
    TRIG_HW_WAIT = 2'b10,
    TRIG_RSVD    = 2'b11
  } trig_sel_e;
endpackage

// File: rtl/adc_wg_regs.sv
module adc_wg_regs
  import adc_wg_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [1:0]         addr,
  input  logic [RES_W-1:0]   wdata,
  input  logic               busy,
  output logic               res8,
  output logic               wake_en,
  output logic               win_out,
  output logic [RES_W-1:0]   lo_lim,
  output logic [RES_W-1:0]   hi_lim,
  output logic [MODE_W-1:0]  mode_rd,
  output logic               mode_wr_blocked
);
  logic mode_wr;

  assign mode_wr         = wr && (addr == ADDR_MODE) && !busy;
  assign mode_wr_blocked = wr && (addr == ADDR_MODE) && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res8    <= 1'b0;
      wake_en <= 1'b0;
      win_out <= 1'b0;
    end else if (mode_wr) begin
      res8    <= wdata[MB_RES8];
      wake_en <= wdata[MB_WAKE];
      win_out <= wdata[MB_WINOUT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_lim <= '0;
      hi_lim <= '1;
    end else if (wr) begin
      if (addr == ADDR_LO) lo_lim <= wdata;
      if (addr == ADDR_HI) hi_lim <= wdata;
    end
  end

  always_comb begin
    mode_rd            = '0;
    mode_rd[MB_RES8]   = res8;
    mode_rd[MB_WAKE]   = wake_en;
    mode_rd[MB_WINOUT] = win_out;
  end
endmodule

// File: rtl/adc_wg_window.sv
module adc_wg_window #(
  parameter int RES_W    = 12,
  parameter int NARROW_W = 8
) (
  input  logic [RES_W-1:0] sample,
  input  logic [RES_W-1:0] lo_lim,
  input  logic [RES_W-1:0] hi_lim,
  input  logic             res8,
  input  logic             win_out,
  output logic             accept
);
  localparam int DROP_W = RES_W - NARROW_W;
  localparam logic [RES_W-1:0] NARROW_MASK = {{NARROW_W{1'b1}}, {DROP_W{1'b0}}};

  function automatic logic judge(input logic [RES_W-1:0] s,
                                 input logic [RES_W-1:0] lo,
                                 input logic [RES_W-1:0] hi,
                                 input logic             outside);
    logic below, above;
    below = (s < lo);
    above = (hi < s);
    return outside ? (below || above) : !(below || above);
  endfunction

  logic [RES_W-1:0] s_eff, lo_eff, hi_eff;

  always_comb begin
    if (res8) begin
      s_eff  = sample & NARROW_MASK;
      lo_eff = lo_lim & NARROW_MASK;
      hi_eff = hi_lim & NARROW_MASK;
    end else begin
      s_eff  = sample;
      lo_eff = lo_lim;
      hi_eff = hi_lim;
    end
    accept = judge(s_eff, lo_eff, hi_eff, win_out);
  end
endmodule

// File: rtl/adc_wg_store.sv
module adc_wg_store #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             accept,
  input  logic [RES_W-1:0] sample,
  output logic [RES_W-1:0] result,
  output logic             irq
);
  logic take;
  assign take = done && accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= take;
      if (take) result <= sample;
    end
  end
endmodule

// File: rtl/adc_window_gate.sv
module adc_window_gate
  import adc_wg_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int NARROW_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_done,
  input  logic [RES_W-1:0]    conv_result,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [RES_W-1:0]    reg_wdata,
  input  logic                conv_enable,
  input  logic                conv_start,
  input  logic                hw_trig,
  input  logic [1:0]          trig_sel,
  input  logic                seq_mode,
  output logic [RES_W-1:0]    result,
  output logic [NARROW_W-1:0] result_hi,
  output logic                conv_irq,
  output logic [MODE_W-1:0]   mode_rd,
  output logic                wake_req
);
  logic             res8, wake_en, win_out;
  logic [RES_W-1:0] lo_lim, hi_lim;
  logic             cmp_accept;
  logic             mode_wr_blocked;
  logic             wake_permitted;

  adc_wg_regs #(.RES_W(RES_W)) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr              (reg_wr),
    .addr            (reg_addr),
    .wdata           (reg_wdata),
    .busy            (conv_enable || conv_start),
    .res8            (res8),
    .wake_en         (wake_en),
    .win_out         (win_out),
    .lo_lim          (lo_lim),
    .hi_lim          (hi_lim),
    .mode_rd         (mode_rd),
    .mode_wr_blocked (mode_wr_blocked)
  );

  adc_wg_window #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_window (
    .sample  (conv_result),
    .lo_lim  (lo_lim),
    .hi_lim  (hi_lim),
    .res8    (res8),
    .win_out (win_out),
    .accept  (cmp_accept)
  );

  adc_wg_store #(.RES_W(RES_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (conv_done),
    .accept (cmp_accept),
    .sample (conv_result),
    .result (result),
    .irq    (conv_irq)
  );

  assign result_hi      = result[RES_W-1 -: NARROW_W];
  assign wake_permitted = (trig_sel_e'(trig_sel) == TRIG_HW_WAIT) && !seq_mode;
  assign wake_req       = wake_en && wake_permitted && hw_trig;
endmodule

// File: rtl/adc_window_gate_sva.sv
module adc_window_gate_sva #(
  parameter int RES_W  = 12,
  parameter int MODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_result,
  input logic              cmp_accept,
  input logic              conv_irq,
  input logic [RES_W-1:0]  result,
  input logic [MODE_W-1:0] mode_rd,
  input logic              mode_wr_blocked,
  input logic              wake_req,
  input logic              hw_trig,
  input logic [1:0]        trig_sel,
  input logic              seq_mode
);
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_irq |-> $past(conv_done)); // R4
  AST_ACCEPT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && cmp_accept) |=> conv_irq); // R4
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !cmp_accept) |=> (!conv_irq && $stable(result))); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_irq |-> $stable(result)); // R5
  AST_STORE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_irq |-> (result == $past(conv_result))); // R2
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_blocked |=> $stable(mode_rd)); // R9
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (hw_trig && trig_sel == 2'b10 && !seq_mode)); // R10
endmodule

bind adc_window_gate adc_window_gate_sva #(.RES_W(RES_W), .MODE_W(adc_wg_pkg::MODE_W)) u_sva (
  .clk             (clk),
  .rst_n           (rst_n),
  .conv_done       (conv_done),
  .conv_result     (conv_result),
  .cmp_accept      (cmp_accept),
  .conv_irq        (conv_irq),
  .result          (result),
  .mode_rd         (mode_rd),
  .mode_wr_blocked (mode_wr_blocked),
  .wake_req        (wake_req),
  .hw_trig         (hw_trig),
  .trig_sel        (trig_sel),
  .seq_mode        (seq_mode)
);

// File: tb/adc_window_gate_tb.sv
`timescale 1ns/1ps
module adc_window_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_result = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic        conv_enable = 1'b0;
  logic        conv_start = 1'b0;
  logic        hw_trig = 1'b0;
  logic [1:0]  trig_sel = '0;
  logic        seq_mode = 1'b0;
  logic [11:0] result;
  logic [7:0]  result_hi;
  logic        conv_irq;
  logic [7:0]  mode_rd;
  logic        wake_req;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0]  m_mode = 8'h00;
  logic [11:0] m_lo = 12'h000;
  logic [11:0] m_hi = 12'hFFF;
  logic [11:0] m_res = 12'h000;

  always #5 clk = ~clk;

  adc_window_gate u_dut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .conv_enable(conv_enable), .conv_start(conv_start), .hw_trig(hw_trig),
    .trig_sel(trig_sel), .seq_mode(seq_mode), .result(result),
    .result_hi(result_hi), .conv_irq(conv_irq), .mode_rd(mode_rd), .wake_req(wake_req)
  );

  function automatic bit exp_accept(input logic [11:0] s, input logic [11:0] lo,
                                    input logic [11:0] hi, input bit narrow, input bit outside);
    int sv, lv, hv;
    sv = narrow ? int'(s >> 4) : int'(s);
    lv = narrow ? int'(lo >> 4) : int'(lo);
    hv = narrow ? int'(hi >> 4) : int'(hi);
    if (outside) return (sv < lv) || (sv > hv);
    return (sv >= lv) && (sv <= hv);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive after a falling edge, check at the next falling edge
  task automatic cyc(input bit done, input logic [11:0] s, input bit wr,
                     input logic [1:0] addr, input logic [11:0] wd,
                     input bit en, input bit st, input string req);
    bit acc;
    conv_done = done; conv_result = s;
    reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    conv_enable = en; conv_start = st;
    acc = done && exp_accept(s, m_lo, m_hi, m_mode[0], m_mode[3]);
    if (acc) m_res = s;
    if (wr) begin
      if (addr == 2'd0 && !(en || st)) m_mode = wd[7:0] & 8'h0D;
      if (addr == 2'd1) m_lo = wd;
      if (addr == 2'd2) m_hi = wd;
    end
    @(negedge clk);
    conv_done = 1'b0; reg_wr = 1'b0; conv_enable = 1'b0; conv_start = 1'b0;
    check({req, " irq R4"}, 32'(conv_irq), 32'(acc));
    check({req, " result R5"}, 32'(result), 32'(m_res));
    check("R7 result_hi", 32'(result_hi), 32'(m_res[11:4]));
    check("R8 mode_rd", 32'(mode_rd), 32'(m_mode));
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [11:0] d);
    cyc(1'b0, 12'h0, 1'b1, a, d, 1'b0, 1'b0, "cfg");
  endtask

  task automatic conv(input logic [11:0] s, input string req);
    cyc(1'b1, s, 1'b0, 2'd0, 12'h0, 1'b0, 1'b0, req);
  endtask

  task automatic wake_chk(input bit trig, input logic [1:0] ts, input bit seq);
    bit exp;
    hw_trig = trig; trig_sel = ts; seq_mode = seq;
    #1;
    exp = m_mode[2] && trig && ts == 2'b10 && !seq;
    check("R10 wake_req", 32'(wake_req), 32'(exp));
    hw_trig = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode reset", 32'(mode_rd), 32'h00);
    check("R1 result reset", 32'(result), 32'h000);
    check("R1 irq reset", 32'(conv_irq), 32'h0);
    conv(12'h000, "R1 accept min");
    conv(12'hFFF, "R1 accept max");
    cyc(1'b0, 12'h0, 1'b0, 2'd0, 12'h0, 1'b0, 1'b0, "R4 idle after pulse");

    // R2 inclusive inside
    wr_reg(2'd1, 12'h100); wr_reg(2'd2, 12'h200);
    conv(12'h100, "R2 lower edge");
    conv(12'h200, "R2 upper edge");
    conv(12'h0FF, "R2 below");
    conv(12'h201, "R2 above");
    conv(12'h180, "R2 middle");
    // R3 strict outside
    wr_reg(2'd0, 12'h008);
    conv(12'h100, "R3 lower edge");
    conv(12'h200, "R3 upper edge");
    conv(12'h0FF, "R3 below");
    conv(12'h150, "R3 inside");
    conv(12'h201, "R3 above");
    // R6 8-bit compare
    wr_reg(2'd0, 12'h001);
    wr_reg(2'd1, 12'h105); wr_reg(2'd2, 12'h1F3);
    conv(12'h100, "R6 narrow low");
    conv(12'h1FF, "R6 narrow high");
    conv(12'h0FF, "R6 narrow below");
    wr_reg(2'd0, 12'h000);
    conv(12'h100, "R6 wide low");
    // R8 reserved bits, R9 lock
    wr_reg(2'd0, 12'h0FF);
    check("R8 write FF", 32'(mode_rd), 32'h0D);
    cyc(1'b0, 12'h0, 1'b1, 2'd0, 12'h000, 1'b1, 1'b0, "R9 en lock");
    check("R9 locked en", 32'(mode_rd), 32'h0D);
    cyc(1'b0, 12'h0, 1'b1, 2'd0, 12'h000, 1'b0, 1'b1, "R9 start lock");
    check("R9 locked start", 32'(mode_rd), 32'h0D);
    cyc(1'b0, 12'h0, 1'b1, 2'd1, 12'h055, 1'b1, 1'b1, "R9 limit open");
    // R10 wake gating (wake enabled now)
    for (int t = 0; t < 4; t++) begin
      wake_chk(1'b1, 2'(t), 1'b0);
      wake_chk(1'b1, 2'(t), 1'b1);
      wake_chk(1'b0, 2'(t), 1'b0);
    end
    wr_reg(2'd0, 12'h000);
    wake_chk(1'b1, 2'b10, 1'b0);

    // constrained random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [11:0] s;
      k = $urandom_range(0, 9);
      if (k == 0) begin
        cyc(1'b0, 12'h0, 1'b1, 2'd0, 12'($urandom), $urandom_range(0, 3) == 0,
            $urandom_range(0, 3) == 0, "R9 rnd mode");
      end else if (k == 1) begin
        cyc(1'b0, 12'h0, 1'b1, 2'($urandom_range(1, 2)), 12'($urandom), 1'b0, 1'b0, "cfg rnd");
      end else begin
        case ($urandom_range(0, 2))
          0: s = m_lo + 12'($urandom_range(0, 2)) - 12'd1;
          1: s = m_hi + 12'($urandom_range(0, 2)) - 12'd1;
          default: s = 12'($urandom);
        endcase
        cyc(1'b1, s, 1'b0, 2'd0, 12'h0, 1'b0, 1'b0, "R2 R3 R6 rnd");
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule